// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block sits on the read path of a flash memory model. While an embedded program or erase runs, it answers each read with a status word instead of array contents. When the operation ends, it passes array data through unchanged. It holds a busy timer that stands in for the duration of the operation, so the surrounding model needs no clock-accurate engine.

An operation starts with a one-cycle `op_start` pulse. `op_kind` selects program (0) or erase (1), and `op_wbit` carries bit 7 of the word being programmed. During the operation, software can tell it is busy in two ways, and both work on every read:

- Bit 7 reads as the inverse of the written bit 7 during a program, and as 0 during an erase.
- Bit 6 flips on every read access. It does not change on idle cycles.

Reads answer one cycle after the strobe, and the result stays on `rd_data` until the next read.

Top module: `flash_poll_status`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `busy` is 0, `rd_vld` is 0 and `rd_data` is all zeros.
- R2: An accepted program start (`op_start`=1, `op_kind`=0, `busy`=0 at the edge) makes `busy` read 1 for exactly PROG_CYCLES cycles after that edge, then 0.
- R3: An accepted erase start (`op_kind`=1) makes `busy` read 1 for exactly ERASE_CYCLES cycles after that edge, then 0.
- R4: An `op_start` sampled while `busy` is 1 is ignored: the running operation keeps its end time, its kind and its bit 7 value.
- R5: A read sampled while a program is busy returns bit 7 equal to the inverse of the programmed bit 7 (`op_wbit`).
- R6: A read sampled while an erase is busy returns bit 7 = 0.
- R7: Bit 6 of a busy read is 0 on the first read after a start and inverts on each following busy read. Cycles without a read leave it unchanged.
- R8: During a busy read, every bit other than 7 and 6 reads 0.
- R9: A read sampled while `busy` is 0 returns `arr_rdata` exactly, including a read on the same edge as an accepted start.
- R10: `rd_vld` is 1 exactly in the cycle after a sampled `rd_stb`. On cycles with no strobe, `rd_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | One-cycle start of an embedded operation |
| op_kind | input | 1 | 0 = program, 1 = erase |
| op_wbit | input | 1 | Bit 7 of the word being programmed |
| rd_stb | input | 1 | Read strobe |
| arr_rdata | input | DW | Array data for the addressed location |
| busy | output | 1 | Embedded operation running |
| rd_data | output | DW | Read result, either array data or status |
| rd_vld | output | 1 | `rd_data` updated by the previous strobe |

## Verification
A wrong internal state shows at the ports within a single cycle:

- A busy counter that is loaded wrongly, or restarted by an ignored start, moves the falling edge of `busy` away from the cycle the bench predicts.
- A latched kind or bit that is lost corrupts bit 7 on the very next busy read.
- A toggle flop that is not cleared on start, or that flips on idle cycles, gives the wrong bit 6 on the first read after the fault.

Random strobes with gaps, and starts issued during busy periods, expose each of these against the model computed in the bench.

// File: rtl/fps_pkg.sv
package fps_pkg;
  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_e;

  typedef struct packed {
    logic     busy;
    op_kind_e kind;
    logic     inv7;
    logic     tgl;
  } poll_state_t;
endpackage

// File: rtl/fps_op_timer.sv
module fps_op_timer
  import fps_pkg::*;
#(
  parameter int PROG_CYCLES  = 500,
  parameter int ERASE_CYCLES = 2000
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     op_start,
  input  op_kind_e op_kind,
  output logic     accept,
  output logic     busy
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] PLOAD = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] ELOAD = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign accept = op_start && !busy_q;
  assign busy   = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= (op_kind == OP_PROG) ? PLOAD : ELOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R4
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));

  // R2
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && cnt_q == '0 && !op_start) |=> !busy_q);
endmodule

// File: rtl/fps_stat_track.sv
module fps_stat_track
  import fps_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     accept,
  input  op_kind_e op_kind,
  input  logic     op_wbit,
  input  logic     busy,
  input  logic     rd_stb,
  output op_kind_e kind_q,
  output logic     inv7_q,
  output logic     tgl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q <= OP_PROG;
      inv7_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else if (accept) begin
      kind_q <= op_kind;
      inv7_q <= ~op_wbit;
      tgl_q  <= 1'b0;
    end else if (busy && rd_stb) begin
      tgl_q  <= ~tgl_q;
    end
  end

  // R7
  tgl_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_stb && !accept) |=> (tgl_q != $past(tgl_q)));

  // R7
  tgl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb && !accept) |=> $stable(tgl_q));

  // R4
  kind_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept) |=> ($stable(kind_q) && $stable(inv7_q)));
endmodule

// File: rtl/fps_rd_mux.sv
module fps_rd_mux
  import fps_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_stb,
  input  poll_state_t   st,
  input  logic [DW-1:0] arr_rdata,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld
);
  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;

  logic [DW-1:0] stat_word;

  always_comb begin
    stat_word           = '0;
    stat_word[POLL_BIT] = (st.kind == OP_PROG) ? st.inv7 : 1'b0;
    stat_word[TOG_BIT]  = st.tgl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_stb;
      if (rd_stb) rd_data <= st.busy ? stat_word : arr_rdata;
    end
  end

  // R10
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> rd_vld);

  // R10
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_stb |=> (!rd_vld && $stable(rd_data)));

  // R6
  erase_low_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && st.busy && st.kind == OP_ERASE) |=> !rd_data[POLL_BIT]);

  // R8
  quiet_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && st.busy) |=> ($countones(rd_data) <= 2 && rd_data[TOG_BIT-1:0] == '0));
endmodule

// File: rtl/flash_poll_status.sv
module flash_poll_status
  import fps_pkg::*;
#(
  parameter int DW           = 16,
  parameter int PROG_CYCLES  = 500,
  parameter int ERASE_CYCLES = 2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_start,
  input  logic          op_kind,
  input  logic          op_wbit,
  input  logic          rd_stb,
  input  logic [DW-1:0] arr_rdata,
  output logic          busy,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld
);
  op_kind_e    kind_in;
  op_kind_e    kind_q;
  logic        accept;
  logic        busy_w;
  logic        inv7_q;
  logic        tgl_q;
  poll_state_t st;

  assign kind_in = op_kind_e'(op_kind);

  fps_op_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .op_start(op_start),
    .op_kind (kind_in),
    .accept  (accept),
    .busy    (busy_w)
  );

  fps_stat_track u_track (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .op_kind(kind_in),
    .op_wbit(op_wbit),
    .busy   (busy_w),
    .rd_stb (rd_stb),
    .kind_q (kind_q),
    .inv7_q (inv7_q),
    .tgl_q  (tgl_q)
  );

  assign st = '{busy: busy_w, kind: kind_q, inv7: inv7_q, tgl: tgl_q};

  fps_rd_mux #(.DW(DW)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .rd_stb   (rd_stb),
    .st       (st),
    .arr_rdata(arr_rdata),
    .rd_data  (rd_data),
    .rd_vld   (rd_vld)
  );

  assign busy = busy_w;

  // R5
  prog_inv_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && busy_w && kind_q == OP_PROG) |=> (rd_data[7] == $past(inv7_q)));

  // R9
  idle_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !busy_w) |=> (rd_data == $past(arr_rdata)));
endmodule

// File: tb/flash_poll_status_bench.sv
module flash_poll_status_bench;
  localparam int CLK_NS = 10;
  localparam int DW     = 16;
  localparam int PC     = 12;
  localparam int EC     = 30;

  logic          clk = 1'b0;
  logic          rst;
  logic          op_start, op_kind, op_wbit, rd_stb;
  logic [DW-1:0] arr_rdata;
  logic          busy, rd_vld;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;

  int            m_left = 0;
  logic          m_kind = 1'b0;
  logic          m_w7   = 1'b0;
  logic          m_tgl  = 1'b0;
  logic          m_ign  = 1'b0;
  logic [DW-1:0] m_last = '0;

  flash_poll_status #(.DW(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_flash_poll_status (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind), .op_wbit(op_wbit),
    .rd_stb(rd_stb), .arr_rdata(arr_rdata), .busy(busy), .rd_data(rd_data), .rd_vld(rd_vld)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [DW-1:0] stat_word(logic k, logic w7, logic t);
    logic [DW-1:0] r;
    r    = '0;
    r[7] = k ? 1'b0 : ~w7;
    r[6] = t;
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic st, logic kind, logic w7, logic rd, logic [DW-1:0] arr);
    logic          pre_busy, pre_kind;
    logic [DW-1:0] ed;
    @(negedge clk);
    op_start = st; op_kind = kind; op_wbit = w7; rd_stb = rd; arr_rdata = arr;
    pre_busy = (m_left > 0);
    pre_kind = m_kind;
    ed = arr;
    if (rd) begin
      if (pre_busy) begin
        ed    = stat_word(m_kind, m_w7, m_tgl);
        m_tgl = ~m_tgl;
      end
      m_last = ed;
    end
    if (m_left == 0 && st) begin
      m_left = kind ? EC : PC;
      m_kind = kind; m_w7 = w7; m_tgl = 1'b0; m_ign = 1'b0;
    end else if (m_left > 0) begin
      if (st) m_ign = 1'b1;
      m_left--;
    end
    @(posedge clk); #1;
    chk(m_ign ? "R4" : (m_kind ? "R3" : "R2"), 32'(busy), 32'(m_left > 0));
    chk("R10", 32'(rd_vld), 32'(rd));
    if (!rd) chk("R10", 32'(rd_data), 32'(m_last));
    else if (pre_busy) begin
      chk(pre_kind ? "R6" : "R5", 32'(rd_data[7]), 32'(ed[7]));
      chk("R7", 32'(rd_data[6]), 32'(ed[6]));
      chk("R8", 32'({rd_data[DW-1:8], rd_data[5:0]}), 32'd0);
    end else chk("R9", 32'(rd_data), 32'(arr));
  endtask

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; op_start = 0; op_kind = 0; op_wbit = 0; rd_stb = 0; arr_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 32'(busy), 0); chk("R1", 32'(rd_vld), 0); chk("R1", 32'(rd_data), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", 32'(busy), 0); chk("R1", 32'(rd_vld), 0); chk("R1", 32'(rd_data), 0);
    // R9 idle reads
    step(0, 0, 0, 1, 16'hA5C3);
    step(0, 0, 0, 1, 16'hFFFF);
    // R5 R7 program with bit7 = 1, reads with gaps
    step(1, 0, 1, 0, '0);
    for (int i = 0; i < PC + 3; i++) step(0, 0, 0, (i % 3) != 1, 16'(i * 4099));
    // R9 read on start edge, then program with bit7 = 0
    step(1, 0, 0, 1, 16'h1234);
    for (int i = 0; i < PC + 2; i++) step(0, 0, 0, 1'b1, 16'h0F0F);
    // R3 R4 R6 erase with starts issued while busy
    step(1, 1, 1, 1, 16'h7777);
    for (int i = 0; i < EC + 2; i++) step((i % 4) == 0, (i % 8) == 0 ? 1'b0 : 1'b1, 1'b1, (i % 2) == 0, 16'hC0DE);
    // back-to-back starts
    for (int i = 0; i < 3 * EC; i++) step(1'b1, i[0], 1'b0, 1'b1, 16'hBEEF);
    // random phase
    for (int i = 0; i < 4000; i++)
      step(($urandom % 10) == 0, $urandom % 2, $urandom % 2, ($urandom % 2) == 0, 16'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule